// File: doc/BRIEF.md
# Half-Chip Slip Code Timing Generator

This block produces the local spreading-code timing for a spread-spectrum receiver during code acquisition and tracking. A numerically controlled oscillator, set by a frequency control word, produces enable ticks at twice the chip rate. Every second tick steps a 10-stage maximal-length code generator. Every tick steps a three-stage tap line that holds early, prompt and late copies of the code, each half a chip apart.

When an acquisition threshold test fails, the searching logic pulses `slip_req`. The block then adds one extra half-chip tick to the tick stream. This advances the code generator and the taps by half a chip, with no clock inversion and no phase-shifted clock. Everything runs on one system clock, and every state element is stepped by a clock enable. The block has no data stream, so all pins are plain control and status pins and none applies back-pressure. An epoch pulse marks the start of each code period, and an acknowledge pulse reports each applied slip.

Top module: `halfchip_code_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block shows the following from the next cycle on: `half_tick`, `chip_tick`, `epoch` and `slip_ack` low, and `early`, `prompt` and `late` equal to 2'b01.
- R2: A 32-bit accumulator adds `fcw` on every cycle out of reset. Each carry out of the add makes `half_tick` high for exactly one cycle, in the cycle after that add.
- R3: `chip_tick` is high on every second `half_tick`, counted from reset, so the first `chip_tick` comes with the second `half_tick`. The code generator steps only on `chip_tick`.
- R4: Reset loads the generator from `seed`, or from 1 when `seed` is zero. Its output bit is stage 0. On each step it shifts toward stage 0, and stage 9 receives stage 0 XOR stage 3. A chip is encoded as 2'b01 for bit 0 (+1) and 2'b11 for bit 1 (−1).
- R5: On each `half_tick`, `early` takes the current generator output, `prompt` takes the old `early`, and `late` takes the old `prompt`.
- R6: A one-cycle `slip_req` sets a pending slip. The pending slip becomes one extra `half_tick` in the first following cycle that has no NCO tick. Each slip adds exactly one tick over any window that contains it.
- R7: When a pending slip meets an NCO tick, the inserted tick is deferred by one cycle. No tick is lost, so a window keeps every NCO tick plus every slip.
- R8: `slip_ack` is high for one cycle, in the cycle after the inserted tick.
- R9: `epoch` is high for one cycle, in the cycle after the generator step that returns it to its reset state. Consecutive epochs are exactly 1023 `chip_tick`s apart, with or without slips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcw | input | 32 | Frequency control word of the half-chip NCO |
| seed | input | 10 | Code generator start state, loaded in reset |
| slip_req | input | 1 | One-cycle request to advance the code by half a chip |
| half_tick | output | 1 | Half-chip enable, NCO ticks plus inserted ticks |
| chip_tick | output | 1 | Chip enable, every second half-chip tick |
| early | output | 2 | Early code copy (01 = +1, 11 = −1) |
| prompt | output | 2 | Prompt code copy, half a chip after early |
| late | output | 2 | Late code copy, half a chip after prompt |
| epoch | output | 1 | Code period start pulse |
| slip_ack | output | 1 | Pulse one cycle after a slip has been applied |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator and a 10-stage generator with a 1023-chip period. With these values the bench can reach several complete code periods at NCO rates of one tick per two, three and four cycles. At one tick per two cycles, NCO ticks fall on alternating cycles, so some slip requests meet an NCO tick and take the deferral path. At one tick per four cycles, inserted ticks always find a free cycle. A zero seed and a nonzero seed are both exercised through reset.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  localparam int CODE_W = 2;

  typedef logic [CODE_W-1:0] chip_code_t;

  localparam chip_code_t CODE_PLUS  = 2'b01;
  localparam chip_code_t CODE_MINUS = 2'b11;

  function automatic chip_code_t encode_chip(input logic b);
    return b ? CODE_MINUS : CODE_PLUS;
  endfunction

endpackage

// File: rtl/code_nco.sv
module code_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] fcw,
  output logic             tick
);

  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, acc_q} + {1'b0, fcw};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      tick  <= sum[ACC_W];
    end
  end

endmodule

// File: rtl/slip_inserter.sv
module slip_inserter (
  input  logic clk,
  input  logic rst_n,
  input  logic nco_tick,
  input  logic slip_req,
  output logic half_tick,
  output logic slip_ack
);

  logic pend_q;
  logic ins_fire;

  // an inserted tick only uses a cycle the NCO leaves free
  assign ins_fire  = pend_q && !nco_tick;
  assign half_tick = nco_tick || ins_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      slip_ack <= 1'b0;
    end else begin
      pend_q   <= (pend_q && !ins_fire) || slip_req;
      slip_ack <= ins_fire;
    end
  end

  // R7
  slip_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && nco_tick) |=> pend_q);

  // R6
  slip_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_req |=> pend_q);

endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int             W    = 10,
  parameter logic [W-1:0]   TAPS = 10'b00_0000_1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic         bit_out,
  output logic         epoch
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] st_q;
  logic [W-1:0] start_q;
  logic [W-1:0] st_nxt;
  logic         fb;

  assign fb      = ^(st_q & TAPS);
  assign st_nxt  = {fb, st_q[W-1:1]};
  assign bit_out = st_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= (seed == '0) ? ONE : seed;
      start_q <= (seed == '0) ? ONE : seed;
      epoch   <= 1'b0;
    end else begin
      epoch <= step && (st_nxt == start_q);
      if (step) st_q <= st_nxt;
    end
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);

  // R9
  epoch_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (epoch == (st_q == start_q)));

endmodule

// File: rtl/tap_line.sv
module tap_line #(
  parameter int NSTAGE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [NSTAGE-1:0] taps
);

  logic [NSTAGE-1:0] st_q;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)        st_q[i] <= 1'b0;
        else if (shift_en) st_q[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)        st_q[i] <= 1'b0;
        else if (shift_en) st_q[i] <= st_q[i-1];
      end
    end
  end

  assign taps = st_q;

  // R5
  tap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (st_q[NSTAGE-1:1] == $past(st_q[NSTAGE-2:0])));

  // R5
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(st_q));

endmodule

// File: rtl/halfchip_code_timer.sv
module halfchip_code_timer #(
  parameter int ACC_W  = 32,
  parameter int LFSR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  fcw,
  input  logic [LFSR_W-1:0] seed,
  input  logic              slip_req,
  output logic              half_tick,
  output logic              chip_tick,
  output logic [1:0]        early,
  output logic [1:0]        prompt,
  output logic [1:0]        late,
  output logic              epoch,
  output logic              slip_ack
);

  import hcs_pkg::*;

  localparam int NTAP = 3;

  logic            nco_tick;
  logic            phase_q;
  logic            code_bit;
  logic [NTAP-1:0] tap_bits;

  code_nco #(.ACC_W(ACC_W)) u_nco (
    .clk  (clk),
    .rst_n(rst_n),
    .fcw  (fcw),
    .tick (nco_tick)
  );

  slip_inserter u_slip (
    .clk      (clk),
    .rst_n    (rst_n),
    .nco_tick (nco_tick),
    .slip_req (slip_req),
    .half_tick(half_tick),
    .slip_ack (slip_ack)
  );

  // divide the half-chip stream by two with an enable-driven phase bit
  always_ff @(posedge clk) begin
    if (!rst_n)         phase_q <= 1'b0;
    else if (half_tick) phase_q <= !phase_q;
  end

  assign chip_tick = half_tick && phase_q;

  pn_lfsr #(.W(LFSR_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed   (seed),
    .step   (chip_tick),
    .bit_out(code_bit),
    .epoch  (epoch)
  );

  tap_line #(.NSTAGE(NTAP)) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(half_tick),
    .din     (code_bit),
    .taps    (tap_bits)
  );

  assign early  = encode_chip(tap_bits[0]);
  assign prompt = encode_chip(tap_bits[1]);
  assign late   = encode_chip(tap_bits[2]);

  // R3
  chip_on_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_tick |-> half_tick);

  // R3
  chip_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_tick |=> !chip_tick);

  // R8
  ack_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slip_ack) |-> $past(half_tick));

endmodule

// File: tb/test_halfchip_code_timer.sv
module test_halfchip_code_timer;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fcw = 32'h4000_0000;
  logic [9:0]  seed = 10'h2A5;
  logic        slip_req = 1'b0;
  logic        half_tick, chip_tick, epoch, slip_ack;
  logic [1:0]  early, prompt, late;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  halfchip_code_timer i_halfchip_code_timer (
    .clk(clk), .rst_n(rst_n), .fcw(fcw), .seed(seed), .slip_req(slip_req),
    .half_tick(half_tick), .chip_tick(chip_tick), .early(early),
    .prompt(prompt), .late(late), .epoch(epoch), .slip_ack(slip_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] enc(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

  typedef struct packed {
    logic       half;
    logic       chip;
    logic [1:0] e;
    logic [1:0] p;
    logic [1:0] l;
    logic       ep;
    logic       ack;
  } exp_t;

  exp_t sb_q[$];

  // reference state, built from the requirements
  logic [31:0] m_acc;
  logic        m_tick, m_pend, m_phase, m_ack, m_ep;
  logic [9:0]  m_gen, m_start;
  logic [2:0]  m_sr;

  // driver side of the scoreboard: one expected item per cycle
  always @(posedge clk) begin
    logic        fire, half, chip;
    logic [32:0] sum;
    logic [9:0]  nxt;
    exp_t        it;
    if (!rst_n) begin
      m_acc = '0; m_tick = 0; m_pend = 0; m_phase = 0; m_ack = 0; m_ep = 0;
      m_gen = (seed == 0) ? 10'd1 : seed;
      m_start = m_gen;
      m_sr = '0;
    end else begin
      fire = m_pend && !m_tick;
      half = m_tick || fire;
      chip = half && m_phase;
      if (half) begin
        m_sr = {m_sr[1:0], m_gen[0]};
        m_phase = !m_phase;
      end
      m_ep = 1'b0;
      if (chip) begin
        nxt = {m_gen[0] ^ m_gen[3], m_gen[9:1]};
        m_ep = (nxt == m_start);
        m_gen = nxt;
      end
      m_ack = fire;
      m_pend = (m_pend && !fire) || slip_req;
      sum = {1'b0, m_acc} + {1'b0, fcw};
      m_tick = sum[32];
      m_acc = sum[31:0];
    end
    it.half = m_tick || (m_pend && !m_tick);
    it.chip = it.half && m_phase;
    it.e = enc(m_sr[0]);
    it.p = enc(m_sr[1]);
    it.l = enc(m_sr[2]);
    it.ep = m_ep;
    it.ack = m_ack;
    sb_q.push_back(it);
  end

  // monitor side: pop and compare away from the active edge
  int chips_since = 0;
  always @(negedge clk) begin
    exp_t x;
    if (sb_q.size() > 0 && !done) begin
      x = sb_q.pop_front();
      check(half_tick == x.half, "R2/R6 half_tick", half_tick, x.half);
      check(chip_tick == x.chip, "R3 chip_tick", chip_tick, x.chip);
      check(early == x.e, "R4 early code", early, x.e);
      check(prompt == x.p, "R5 prompt", prompt, x.p);
      check(late == x.l, "R5 late", late, x.l);
      check(epoch == x.ep, "R9 epoch", epoch, x.ep);
      check(slip_ack == x.ack, "R8 slip_ack", slip_ack, x.ack);
      if (!rst_n) chips_since = 0;
      else begin
        if (epoch) begin
          check(chips_since == 1023, "R9 epoch spacing", chips_since, 1023);
          chips_since = 0;
        end
        if (chip_tick) chips_since++;
      end
    end
  end

  task automatic do_reset(input logic [9:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    seed = s;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(!half_tick && !chip_tick && !epoch && !slip_ack, "R1 reset pulses",
          {half_tick, chip_tick, epoch, slip_ack}, 0);
    check(early == 2'b01 && prompt == 2'b01 && late == 2'b01, "R1 reset taps",
          {early, prompt, late}, 6'b010101);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input int slip_every);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      slip_req = (slip_every > 0) && (i % slip_every == 0);
    end
    @(negedge clk);
    slip_req = 1'b0;
  endtask

  // count half ticks over n cycles while issuing slips at given offsets
  task automatic window(input int n, input int period, input int s1, input int s2,
                        input string tag);
    int cnt = 0;
    int exp_cnt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (half_tick) cnt++;
      slip_req = (i == s1) || (i == s2);
    end
    slip_req = 1'b0;
    exp_cnt = n / period + 2;
    check(cnt == exp_cnt, tag, cnt, exp_cnt);
  endtask

  initial begin
    fcw = 32'h8000_0000;
    do_reset(10'h2A5);
    run(9000, 0);                 // R9 two full periods at two cycles per tick
    fcw = 32'h4000_0000;
    run(20, 0);
    // R6: four-cycle ticks leave free cycles for each slip
    window(400, 4, 10, 121, "R6 slip adds one tick");
    run(20, 0);
    fcw = 32'h8000_0000;
    run(20, 0);
    // R7: alternating ticks, offsets of different parity force one deferral
    window(400, 2, 10, 31, "R7 no tick lost on collision");
    run(20, 0);
    fcw = 32'h5555_5555;
    run(8000, 37);                // mixed rate with periodic slips
    fcw = 32'h8000_0000;
    do_reset(10'h000);            // R4 zero seed start
    run(5000, 53);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule